// File: doc/BRIEF.md
# Selectable-Ratio Clock Divider With Gated Outputs

This block picks one of two reference clocks and divides it by 2, 4, 5 or 8, using a single divider shared by two outputs. Each output chooses between the undivided reference and the divided clock. Each output also has its own active-low enable, which starts and stops that output cleanly, with no shortened high pulse.

The block is modelled in one synchronous domain running on `clk`. Each reference clock is represented by an edge strobe, `edge_a` or `edge_b`, that is high for one `clk` cycle at every half-period boundary of that reference, whether the boundary is a rise or a fall. The undivided reference is therefore a level that toggles on every selected strobe. Because the divider counts half-periods, every ratio, including the odd ratio of 5, gives a 50% duty cycle. The outputs are ordinary logic levels.

Top module: `selratio_clkdiv`

## Requirements
- R1: `ref_sel` = 0 selects the `edge_a` strobes and `ref_sel` = 1 selects the `edge_b` strobes. Strobes on the unselected input have no effect on either output.
- R2: While `rst` is high, and in the cycle after it was sampled high, both outputs are 0. Reset also clears the divider.
- R3: The undivided reference level starts at 0 and toggles one cycle after each selected strobe. An enabled output with its `out_sel` bit at 0 shows this level.
- R4: The `ratio` code selects N as follows: 00 gives 2, 01 gives 4, 10 gives 5 and 11 gives 8. The divided level toggles on every Nth selected strobe, so it stays high for N strobes and low for N strobes. An enabled output with its `out_sel` bit at 1 shows this level.
- R5: When `ratio` differs from the value held in the previous cycle, the next cycle has the divider count, the divided level and the reference level cleared to 0. A strobe arriving in that same cycle is dropped, and counting restarts from phase zero.
- R6: Each `out_en_n` bit passes through two synchronizing flops before the output gating uses it.
- R7: An output's gate may change only in a cycle where that output's source level is low. As a result, a high pulse is never cut short, a disabled output stays low, and an enabled output always starts with a full high pulse.
- R8: Both outputs use the same divider. Two enabled outputs that both select the divided clock are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modelling clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_sel | input | 1 | Reference choice: 0 selects strobe A, 1 selects strobe B |
| edge_a | input | 1 | Half-period strobe of reference A |
| edge_b | input | 1 | Half-period strobe of reference B |
| ratio | input | 2 | Division code: 00 gives ÷2, 01 gives ÷4, 10 gives ÷5, 11 gives ÷8 |
| out_sel | input | NOUT | Per-output source: 0 is undivided, 1 is divided |
| out_en_n | input | NOUT | Per-output enable, active low |
| clk_out | output | NOUT | Gated output levels |

## Verification
The assertions assume that `out_sel` does not change while the output it controls is high. Under that assumption, an output falls only when its source level falls or when `ratio` changes. The random stimulus therefore changes an `out_sel` bit only in a cycle where the matching output is sampled low. Ratio and reference changes may occur at any time, because they only cause the outputs to restart from a low level.

// File: rtl/selratio_clkdiv.sv
module selratio_clkdiv #(
  parameter int NOUT        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_sel,
  input  logic            edge_a,
  input  logic            edge_b,
  input  logic [1:0]      ratio,
  input  logic [NOUT-1:0] out_sel,
  input  logic [NOUT-1:0] out_en_n,
  output logic [NOUT-1:0] clk_out
);
  localparam int CW = 3;

  function automatic logic [CW-1:0] last_count(input logic [1:0] code);
    case (code)
      2'b00:   return CW'(1);
      2'b01:   return CW'(3);
      2'b10:   return CW'(4);
      default: return CW'(7);
    endcase
  endfunction

  logic          adv, restart;
  logic [1:0]    ratio_q;
  logic [CW-1:0] cnt;
  logic          ref_q, div_q;

  assign adv     = ref_sel ? edge_b : edge_a;
  assign restart = (ratio != ratio_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= 2'b00;
      cnt     <= '0;
      ref_q   <= 1'b0;
      div_q   <= 1'b0;
    end else if (restart) begin
      ratio_q <= ratio;
      cnt     <= '0;
      ref_q   <= 1'b0;
      div_q   <= 1'b0;
    end else if (adv) begin
      ref_q <= ~ref_q;
      if (cnt == last_count(ratio_q)) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2 reset forces outputs low
  a_r2_reset_low: assert property (@(posedge clk) rst |=> (clk_out == '0));

  // R3 reference level follows every selected strobe
  a_r3_ref_toggle: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart) |=> (ref_q != $past(ref_q)));

  // R4 divided level moves only on a selected strobe
  a_r4_div_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(div_q));

  // R5 ratio change restarts from phase zero
  a_r5_restart_clean: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !div_q && !ref_q));

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic [SYNC_STAGES-1:0] sync;
    logic                   gate;
    logic                   src;

    assign src = out_sel[g] ? div_q : ref_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync <= '1;
        gate <= 1'b0;
      end else begin
        sync <= {sync[SYNC_STAGES-2:0], out_en_n[g]};
        if (!src) gate <= ~sync[SYNC_STAGES-1];
      end
    end

    assign clk_out[g] = src & gate;

    // R7 a high pulse is not cut short by the gate
    a_r7_no_cut: assert property (@(posedge clk) disable iff (rst)
      (clk_out[g] && !adv && !restart) |=> (clk_out[g] || $changed(out_sel[g])));
  end
endmodule

// File: tb/test_selratio_clkdiv.sv
module test_selratio_clkdiv;
  logic       clk = 1'b0;
  logic       rst;
  logic       ref_sel, edge_a, edge_b;
  logic [1:0] ratio, out_sel, out_en_n;
  logic [1:0] clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R2";

  selratio_clkdiv i_selratio_clkdiv (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .edge_a(edge_a), .edge_b(edge_b),
    .ratio(ratio), .out_sel(out_sel), .out_en_n(out_en_n), .clk_out(clk_out)
  );

  always #4 clk = ~clk;

  function automatic int ratio_n(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 5;
      default: return 8;
    endcase
  endfunction

  // reference model built from the requirements
  bit       m_ref, m_div;
  int       m_cnt;
  bit [1:0] m_ratio, m_s1, m_s2, m_gate;

  function automatic bit [1:0] model_out(input logic [1:0] sel);
    bit [1:0] o;
    for (int i = 0; i < 2; i++) o[i] = (sel[i] ? m_div : m_ref) & m_gate[i];
    return o;
  endfunction

  always @(posedge clk) begin
    bit n_ref, n_div;
    int n_cnt;
    bit [1:0] n_gate;
    bit a;
    if (rst) begin
      m_ref = 0; m_div = 0; m_cnt = 0; m_ratio = 0;
      m_s1 = 2'b11; m_s2 = 2'b11; m_gate = 0;
    end else begin
      a = ref_sel ? edge_b : edge_a;
      n_ref = m_ref; n_div = m_div; n_cnt = m_cnt;
      if (ratio != m_ratio) begin
        n_ref = 0; n_div = 0; n_cnt = 0;
      end else if (a) begin
        n_ref = !m_ref;
        if (m_cnt == ratio_n(m_ratio) - 1) begin n_cnt = 0; n_div = !m_div; end
        else n_cnt = m_cnt + 1;
      end
      n_gate = m_gate;
      for (int i = 0; i < 2; i++)
        if (!(out_sel[i] ? m_div : m_ref)) n_gate[i] = !m_s2[i];
      m_ratio = ratio;
      m_ref = n_ref; m_div = n_div; m_cnt = n_cnt;
      m_gate = n_gate;
      m_s2 = m_s1; m_s1 = out_en_n;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit cmp);
    @(negedge clk);
    if (cmp) check(tag, 32'(clk_out), 32'(model_out(out_sel)));
  endtask

  task automatic measure_div(input logic [1:0] code);
    int hi, lo;
    ratio = code; out_sel = 2'b11; out_en_n = 2'b00; ref_sel = 1'b0;
    edge_a = 1'b1; edge_b = 1'b0;
    repeat (40) step(1);
    while (clk_out[1] !== 1'b0) step(0);
    while (clk_out[1] !== 1'b1) step(0);
    hi = 0; while (clk_out[1] === 1'b1 && hi < 40) begin hi++; step(0); end
    lo = 0; while (clk_out[1] === 1'b0 && lo < 40) begin lo++; step(0); end
    check("R4 high run", 32'(hi), 32'(ratio_n(code)));
    check("R4 low run", 32'(lo), 32'(ratio_n(code)));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails + 0 * checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd5591));
    rst = 1'b1; ref_sel = 0; edge_a = 0; edge_b = 0;
    ratio = 2'b00; out_sel = 2'b00; out_en_n = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 out low in reset", 32'(clk_out), 32'h0);
    rst = 1'b0;
    repeat (4) step(1);
    check("R2 idle after reset", 32'(clk_out), 32'h0);

    // R4 per-ratio duty and period
    for (int k = 0; k < 4; k++) measure_div(2'(k));

    // R1 unselected strobe has no effect
    tag = "R1";
    ref_sel = 1'b1; edge_a = 1'b0; edge_b = 1'b0; out_sel = 2'b00;
    repeat (3) step(1);
    edge_a = 1'b1;
    begin
      logic [1:0] held;
      held = clk_out;
      repeat (12) step(1);
      check("R1 unselected strobe ignored", 32'(clk_out), 32'(held));
    end
    edge_a = 0; edge_b = 1'b1;
    repeat (8) step(1);

    // R3 passthrough toggles each strobe
    tag = "R3";
    ref_sel = 1'b0; edge_a = 1'b1; edge_b = 1'b0;
    step(1);
    begin
      logic p;
      p = clk_out[0];
      step(1);
      check("R3 passthrough toggles", 32'(clk_out[0]), 32'(!p));
    end

    // R6 enable latency and R7 gating
    tag = "R6";
    out_en_n = 2'b11;
    repeat (6) step(1);
    check("R6 disabled outputs low", 32'(clk_out), 32'h0);
    out_en_n = 2'b00;
    repeat (8) step(1);

    // R5 ratio change restarts
    tag = "R5";
    out_sel = 2'b11; ratio = 2'b11;
    repeat (5) step(1);
    ratio = 2'b10;
    step(1);
    check("R5 restart low", 32'(clk_out), 32'h0);
    repeat (20) step(1);

    // R8 shared divider
    tag = "R8";
    repeat (10) begin
      step(1);
      check("R8 outputs equal", 32'(clk_out[0]), 32'(clk_out[1]));
    end

    // random mix checked against the model
    tag = "R7";
    for (int n = 0; n < 4000; n++) begin
      edge_a = ($urandom % 3) != 0;
      edge_b = ($urandom % 2) != 0;
      if ($urandom % 97 == 0) ref_sel = !ref_sel;
      if ($urandom % 151 == 0) ratio = 2'($urandom);
      if ($urandom % 23 == 0) out_en_n = 2'($urandom);
      for (int i = 0; i < 2; i++)
        if (clk_out[i] == 1'b0 && $urandom % 41 == 0) out_sel[i] = !out_sel[i];
      if ($urandom % 1500 == 0) begin
        rst = 1'b1; step(0); rst = 1'b0;
        check("R2 output after reset", 32'(clk_out), 32'h0);
      end
      step(1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule